// File: doc/BRIEF.md
# Learn/Recognize Phase Control Sequencer

This block is a synchronous state machine that drives the control lines of a learn-then-recognize associative-memory array. After a start request it issues a clear pulse to the array. It then loads and learns each stored pattern in turn. Each pattern is moved bit by bit into a column shift chain and then applied to the cells while the learning architecture is selected. After the last pattern, the block drives four paired pulses to the per-cell and shared weight-step counters. It then applies a noisy pattern with the learning architecture released. Last, it holds the recognition architecture selected for a fixed dwell, flags completion and returns to idle.

Every dwell length is a parameter. The number of patterns is taken from an input when the run starts. Every output comes straight from a flop, so the array sees clean, glitch-free levels.

Top module: `assoc_phase_seq`

## Requirements
- R1: While idle, a high `start_i` begins a run. For the next CLR_CYC cycles `array_clr_o` is high and every other control output is low. `start_i` has no effect while a run is in progress, including its final done cycle.
- R2: `learn_sel_o` and `recog_sel_o` are never high together. After the last learning step there is one cycle with every control output low before the weight-step pulses begin.
- R3: In each shift segment, `learn_sel_o` and `xfer_en_o` are high for 2*SHIFT_LEN cycles. `shift_pulse_o` is high on the even cycles of the segment, counting from 0, which gives SHIFT_LEN one-cycle pulses. `shift_pulse_o` is never high while `xfer_en_o` is low.
- R4: Each shift segment is followed by LEARN_CYC cycles with `apply_o` and `learn_sel_o` high and `xfer_en_o` low. The shift/learn pair repeats once per pattern, with `xfer_en_o` rising again as `apply_o` falls. The pattern count is `num_pat_i` captured at start, and a value of 0 is treated as 1.
- R5: The weight-step phase lasts 8 cycles. `lcnt_pulse_o` and `gcnt_pulse_o` are equal in every cycle and are high on its even cycles, giving exactly four pulses.
- R6: `wstep_o` (2 bits) is 0 after reset and is cleared when a run starts. During weight-step cycle i it reads i/2, so the pulses see 00, 01, 10, 11 in that order. It then holds 11 until the next run.
- R7: After the weight-step phase, `noise_en_o` and `apply_o` are high for INJ_CYC cycles while `learn_sel_o` is low.
- R8: Next, `recog_sel_o` is high for RECOG_CYC cycles. Then `done_o` is high for exactly one cycle, after which all control outputs are low.
- R9: A synchronous `rst` drives every output low, clears `wstep_o` and abandons any run in progress.
- R10: The first clear cycle appears on the outputs on the clock edge that samples `start_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run when idle |
| num_pat_i | input | NPAT_W | Number of patterns to learn (0 means 1) |
| learn_sel_o | output | 1 | Selects the learning architecture |
| recog_sel_o | output | 1 | Selects the recognition architecture |
| array_clr_o | output | 1 | Clears array sub-circuits |
| shift_pulse_o | output | 1 | Clock pulse for the pattern shift chain |
| xfer_en_o | output | 1 | Allows the shift chain to move data |
| apply_o | output | 1 | Connects the shift chain to the cells |
| lcnt_pulse_o | output | 1 | Step pulse for per-cell weight counters |
| gcnt_pulse_o | output | 1 | Step pulse for the shared weight counter |
| noise_en_o | output | 1 | Mixes noise into the stored pattern |
| wstep_o | output | STEP_W | Current weight-step count |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Runs are made with pattern counts of one, three, the maximum of seven and zero. These show that the shift/learn loop repeats the captured number of times and that zero folds to a single pass. A start pulse in the middle of a run, together with a changed count, shows that both are ignored. Holding start high across several runs exposes the single idle cycle after done. A reset in the middle of a run shows that the sequencer abandons the run and restarts cleanly, with the weight-step count cleared.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_SHIFT,
    ST_LEARN,
    ST_GAP,
    ST_WGEN,
    ST_INJ,
    ST_RECOG,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic learn;
    logic recog;
    logic clr;
    logic shift;
    logic xfer;
    logic apply;
    logic lcnt;
    logic gcnt;
    logic noise;
    logic done;
  } seq_ctrl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_dwell_ctr.sv
module seq_dwell_ctr #(
  parameter int CNT_W = 5,
  parameter int LO_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] len_m1,
  output logic             last,
  output logic [LO_W-1:0]  cnt_lo
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // last cycle of the current dwell
  assign last   = run && (cnt_q == len_m1);
  assign cnt_d  = (!run || last) ? '0 : cnt_q + 1'b1;
  assign cnt_lo = cnt_d[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/seq_pat_ctr.sv
module seq_pat_ctr #(
  parameter int NPAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NPAT_W-1:0] num_i,
  input  logic              adv,
  output logic              is_last
);

  logic [NPAT_W-1:0] tgt_q;
  logic [NPAT_W-1:0] seen_q;

  // true while the pattern now being learned is the final one
  assign is_last = ({1'b0, seen_q} + 1'b1) == {1'b0, tgt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= NPAT_W'(1);
      seen_q <= '0;
    end else if (load) begin
      tgt_q  <= (num_i == '0) ? NPAT_W'(1) : num_i;
      seen_q <= '0;
    end else if (adv) begin
      seen_q <= seen_q + 1'b1;
    end
  end

endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg
  import seq_pkg::*;
#(
  parameter int STEP_W = 2,
  parameter int LO_W   = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_d,
  input  logic [LO_W-1:0]   cnt_lo,
  output seq_ctrl_t         ctrl_q,
  output logic [STEP_W-1:0] wstep_q
);

  seq_ctrl_t         dec;
  logic              even;
  logic [STEP_W-1:0] step;

  assign even = ~cnt_lo[0];
  assign step = cnt_lo[LO_W-1:1];

  always_comb begin
    dec       = '0;
    dec.clr   = (state_d == ST_CLR);
    dec.learn = (state_d == ST_SHIFT) || (state_d == ST_LEARN);
    dec.xfer  = (state_d == ST_SHIFT);
    dec.shift = (state_d == ST_SHIFT) && even;
    dec.apply = (state_d == ST_LEARN) || (state_d == ST_INJ);
    dec.lcnt  = (state_d == ST_WGEN) && even;
    dec.gcnt  = (state_d == ST_WGEN) && even;
    dec.noise = (state_d == ST_INJ);
    dec.recog = (state_d == ST_RECOG);
    dec.done  = (state_d == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      wstep_q <= '0;
    end else begin
      ctrl_q <= dec;
      if (state_d == ST_WGEN)     wstep_q <= step;
      else if (state_d == ST_CLR) wstep_q <= '0;
    end
  end

endmodule

// File: rtl/assoc_phase_seq.sv
module assoc_phase_seq
  import seq_pkg::*;
#(
  parameter int NPAT_W    = 3,
  parameter int SHIFT_LEN = 9,
  parameter int CLR_CYC   = 2,
  parameter int LEARN_CYC = 4,
  parameter int INJ_CYC   = 3,
  parameter int RECOG_CYC = 6,
  parameter int STEP_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [NPAT_W-1:0] num_pat_i,
  output logic              learn_sel_o,
  output logic              recog_sel_o,
  output logic              array_clr_o,
  output logic              shift_pulse_o,
  output logic              xfer_en_o,
  output logic              apply_o,
  output logic              lcnt_pulse_o,
  output logic              gcnt_pulse_o,
  output logic              noise_en_o,
  output logic [STEP_W-1:0] wstep_o,
  output logic              done_o
);

  localparam int NSTEPS    = 1 << STEP_W;
  localparam int SHIFT_CYC = 2 * SHIFT_LEN;
  localparam int WGEN_CYC  = 2 * NSTEPS;
  localparam int MAX_LEN   = imax(imax(imax(CLR_CYC, SHIFT_CYC), imax(LEARN_CYC, WGEN_CYC)),
                                  imax(INJ_CYC, RECOG_CYC));
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int LO_W      = STEP_W + 1;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  len_m1;
  logic              run, last, pat_last, pat_load, pat_adv;
  logic [LO_W-1:0]   cnt_lo;
  seq_ctrl_t         ctrl;
  logic [STEP_W-1:0] wstep;

  assign run = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_CLR:   len_m1 = CNT_W'(CLR_CYC - 1);
      ST_SHIFT: len_m1 = CNT_W'(SHIFT_CYC - 1);
      ST_LEARN: len_m1 = CNT_W'(LEARN_CYC - 1);
      ST_WGEN:  len_m1 = CNT_W'(WGEN_CYC - 1);
      ST_INJ:   len_m1 = CNT_W'(INJ_CYC - 1);
      ST_RECOG: len_m1 = CNT_W'(RECOG_CYC - 1);
      default:  len_m1 = '0;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    pat_load = 1'b0;
    pat_adv  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_CLR;
        pat_load = 1'b1;
      end
      ST_CLR:   if (last) state_d = ST_SHIFT;
      ST_SHIFT: if (last) state_d = ST_LEARN;
      ST_LEARN: if (last) begin
        pat_adv = 1'b1;
        state_d = pat_last ? ST_GAP : ST_SHIFT;
      end
      ST_GAP:   if (last) state_d = ST_WGEN;
      ST_WGEN:  if (last) state_d = ST_INJ;
      ST_INJ:   if (last) state_d = ST_RECOG;
      ST_RECOG: if (last) state_d = ST_DONE;
      ST_DONE:  if (last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  seq_dwell_ctr #(.CNT_W(CNT_W), .LO_W(LO_W)) u_dwell (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .len_m1 (len_m1),
    .last   (last),
    .cnt_lo (cnt_lo)
  );

  seq_pat_ctr #(.NPAT_W(NPAT_W)) u_pat (
    .clk     (clk),
    .rst     (rst),
    .load    (pat_load),
    .num_i   (num_pat_i),
    .adv     (pat_adv),
    .is_last (pat_last)
  );

  seq_out_reg #(.STEP_W(STEP_W), .LO_W(LO_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .cnt_lo  (cnt_lo),
    .ctrl_q  (ctrl),
    .wstep_q (wstep)
  );

  assign learn_sel_o   = ctrl.learn;
  assign recog_sel_o   = ctrl.recog;
  assign array_clr_o   = ctrl.clr;
  assign shift_pulse_o = ctrl.shift;
  assign xfer_en_o     = ctrl.xfer;
  assign apply_o       = ctrl.apply;
  assign lcnt_pulse_o  = ctrl.lcnt;
  assign gcnt_pulse_o  = ctrl.gcnt;
  assign noise_en_o    = ctrl.noise;
  assign done_o        = ctrl.done;
  assign wstep_o       = wstep;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              learn,
  input logic              recog,
  input logic              clr,
  input logic              shift,
  input logic              xfer,
  input logic              apply,
  input logic              lcnt,
  input logic              gcnt,
  input logic              noise,
  input logic              done,
  input logic [STEP_W-1:0] wstep
);

  // R1
  clr_alone_chk: assert property (@(posedge clk) disable iff (rst)
    clr |-> (!learn && !recog && !apply && !noise));

  // R2
  mutex_chk: assert property (@(posedge clk) disable iff (rst)
    !(learn && recog));

  // R2
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(recog) |-> !$past(learn));

  // R3
  shift_gate_chk: assert property (@(posedge clk) disable iff (rst)
    shift |-> xfer);

  // R4
  xfer_apply_chk: assert property (@(posedge clk) disable iff (rst)
    !(xfer && apply));

  // R5
  pulse_pair_chk: assert property (@(posedge clk) disable iff (rst)
    lcnt == gcnt);

  // R6
  wstep_order_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(lcnt) && (wstep != '0)) |-> (wstep == STEP_W'($past(wstep) + 1'b1)));

  // R7
  noise_iso_chk: assert property (@(posedge clk) disable iff (rst)
    noise |-> (!learn && apply));

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind assoc_phase_seq seq_chk #(.STEP_W(STEP_W)) u_seq_chk (
  .clk   (clk),
  .rst   (rst),
  .learn (learn_sel_o),
  .recog (recog_sel_o),
  .clr   (array_clr_o),
  .shift (shift_pulse_o),
  .xfer  (xfer_en_o),
  .apply (apply_o),
  .lcnt  (lcnt_pulse_o),
  .gcnt  (gcnt_pulse_o),
  .noise (noise_en_o),
  .done  (done_o),
  .wstep (wstep_o)
);

// File: tb/tb_assoc_phase_seq.sv
`timescale 1ns/1ps
module tb_assoc_phase_seq;

  localparam int NPAT_W    = 3;
  localparam int SHIFT_LEN = 9;
  localparam int CLR_CYC   = 2;
  localparam int LEARN_CYC = 4;
  localparam int INJ_CYC   = 3;
  localparam int RECOG_CYC = 6;
  localparam int STEP_W    = 2;
  localparam int WDOG      = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [NPAT_W-1:0] num_pat_i = '0;
  logic learn_sel_o, recog_sel_o, array_clr_o, shift_pulse_o, xfer_en_o;
  logic apply_o, lcnt_pulse_o, gcnt_pulse_o, noise_en_o, done_o;
  logic [STEP_W-1:0] wstep_o;

  always #2.5 clk = ~clk;

  assoc_phase_seq #(
    .NPAT_W(NPAT_W), .SHIFT_LEN(SHIFT_LEN), .CLR_CYC(CLR_CYC), .LEARN_CYC(LEARN_CYC),
    .INJ_CYC(INJ_CYC), .RECOG_CYC(RECOG_CYC), .STEP_W(STEP_W)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .num_pat_i(num_pat_i),
    .learn_sel_o(learn_sel_o), .recog_sel_o(recog_sel_o), .array_clr_o(array_clr_o),
    .shift_pulse_o(shift_pulse_o), .xfer_en_o(xfer_en_o), .apply_o(apply_o),
    .lcnt_pulse_o(lcnt_pulse_o), .gcnt_pulse_o(gcnt_pulse_o), .noise_en_o(noise_en_o),
    .wstep_o(wstep_o), .done_o(done_o)
  );

  // Reference model: expected output vector per cycle of a run
  // {done, noise, gcnt, lcnt, apply, xfer, shift, clr, recog, learn, wstep[1:0]}
  logic [11:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  held_ws = 2'b00;
  bit          prev_busy = 0;
  bit          armed = 0;
  bit          after_rst = 1;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;

  function automatic logic [11:0] v(input bit dn, nz, gc, lc, ap, xf, sh, cl, rc, ln,
                                    input int ws);
    return {dn, nz, gc, lc, ap, xf, sh, cl, rc, ln, 2'(ws)};
  endfunction

  task automatic push(input logic [11:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic build_run(input int n);
    int neff;
    neff = (n == 0) ? 1 : n;                       // R4: zero folds to one pattern
    for (int i = 0; i < CLR_CYC; i++)              // R1, R10: clear first
      push(v(0,0,0,0,0,0,0,1,0,0,0), (i == 0) ? "R10" : "R1");
    for (int p = 0; p < neff; p++) begin
      for (int i = 0; i < 2*SHIFT_LEN; i++)        // R3: shift segment
        push(v(0,0,0,0,0,1,(i % 2 == 0),0,0,1,0), "R3");
      for (int i = 0; i < LEARN_CYC; i++)          // R4: apply to cells
        push(v(0,0,0,0,1,0,0,0,0,1,0), "R4");
    end
    push(v(0,0,0,0,0,0,0,0,0,0,0), "R2");          // R2: dead cycle
    for (int i = 0; i < 8; i++)                    // R5, R6: four paired pulses
      push(v(0,0,(i % 2 == 0),(i % 2 == 0),0,0,0,0,0,0,i/2), (i % 2 == 0) ? "R5" : "R6");
    for (int i = 0; i < INJ_CYC; i++)              // R7: noise injection
      push(v(0,1,0,0,1,0,0,0,0,0,3), "R7");
    for (int i = 0; i < RECOG_CYC; i++)            // R8: recognition dwell
      push(v(0,0,0,0,0,0,0,0,1,0,3), "R8");
    push(v(1,0,0,0,0,0,0,0,0,0,3), "R8");          // R8: done flag
  endtask

  always @(posedge clk) begin
    cyc++;
    armed = 1;
    if (rst) begin                                 // R9: reset abandons the run
      exp_q.delete();
      tag_q.delete();
      held_ws = 2'b00;
      prev_busy = 0;
      after_rst = 1;
    end else if (start_i && exp_q.size() == 0 && !prev_busy) begin
      after_rst = 0;
      build_run(int'(num_pat_i));                  // R1: start accepted only when idle
    end
  end

  always @(negedge clk) begin
    logic [11:0] got, exp_v;
    string t;
    if (armed) begin
      got = {done_o, noise_en_o, gcnt_pulse_o, lcnt_pulse_o, apply_o, xfer_en_o,
             shift_pulse_o, array_clr_o, recog_sel_o, learn_sel_o, wstep_o};
      if (exp_q.size() != 0) begin
        exp_v = exp_q.pop_front();
        t = tag_q.pop_front();
        prev_busy = 1;
      end else begin
        exp_v = {10'b0, held_ws};
        t = after_rst ? "R9" : "R8";
        prev_busy = 0;
      end
      held_ws = exp_v[1:0];
      n_cmp++;
      if (got !== exp_v) begin
        n_bad++;
        $display("FAIL %s cycle %0d: got %b expected %b", t, cyc, got, exp_v);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() == 0 && !prev_busy) break;
    end
  endtask

  task automatic run_once(input int n);
    @(negedge clk);
    start_i = 1'b1;
    num_pat_i = NPAT_W'(n);
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);                     // R9: reset state compared each cycle
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_once(1);                                   // single pattern
    run_once(3);                                   // R4: three patterns
    run_once(0);                                   // R4: zero treated as one
    run_once(7);                                   // R4: maximum count
    // R1: start and a new count during a run are ignored
    @(negedge clk);
    start_i = 1'b1;
    num_pat_i = 3'd2;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    start_i = 1'b1;
    num_pat_i = 3'd5;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    // R1, R8: start held high across runs
    @(negedge clk);
    num_pat_i = 3'd1;
    start_i = 1'b1;
    repeat (150) @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    // R9: reset in the middle of the weight-step phase
    @(negedge clk);
    start_i = 1'b1;
    num_pat_i = 3'd1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (27) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    run_once(2);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule